// File: doc/BRIEF.md
# Protection configuration bank with timed write lock

This block holds the configuration of a protection circuit: one control register carrying five detector-disable bits, and eight 8-bit timing and detection-level registers. All of them sit behind a simple CPU register bus with an address, write data, a write strobe and a combinational read-data path. The stored values leave the block towards the protection circuitry. Software reads the stored values back through the same bus.

A separate lock register guards the bank against runaway software. Software first writes a value that sets both of its low bits (the arm step). Within four clock cycles it then writes a value that clears the enable bit and keeps the lock bit set (the commit step). After the commit, every protected register ignores bus writes until the next hardware reset. A `cfg_locked` output reports the lock state. The reset is asynchronous on assertion and synchronised to the clock on release.

Address map: 0 is the lock register, 1 is the control register, and 2 to 9 are the timing and level registers. The three timing registers come first, followed by the five detection-level registers. Addresses 10 to 15 are unmapped.

Top module: `prot_cfg_lock`

## Requirements
- R1: After reset, `cfg_locked` is 0. The lock register reads 0x00, the control register reads 0x20, and addresses 2 to 9 read 0x00.
- R2: The lock register keeps the last written bits 1 (enable) and 0 (lock), and reads them back there. Its bits 7 to 2 always read 0. It stays writable after the lock is set.
- R3: Control register bits 4 to 0 (the detector disables) are read/write. Bits 7 and 6 read 0 and bit 5 reads 1, whatever is written.
- R4: Addresses 2 to 9 each store and return all 8 written bits.
- R5: A lock-register write with bits [1:0] = 2'b11, followed 1 to 4 cycles later by a lock-register write with bits [1:0] = 2'b01, sets `cfg_locked` at the edge of the commit write.
- R6: A commit write arriving 5 or more cycles after the arm write sets no lock, and a commit write with no preceding arm sets no lock.
- R7: During the window, a lock-register write with bits [1:0] equal to 2'b00 or 2'b10 cancels the arm. A later 2'b01 write then sets no lock. A new 2'b11 write restarts the window.
- R8: Writes and reads at other addresses during the window neither cancel nor extend it.
- R9: While `cfg_locked` is 1, writes to addresses 1 to 9 leave their contents unchanged, and reads still return the stored values.
- R10: Once set, `cfg_locked` stays 1 until hardware reset, and a reset clears it together with every register.
- R11: Unmapped addresses 10 to 15 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cfg_locked | output | 1 | High once the lock sequence has completed |
| det_disable | output | 5 | Control register detector-disable bits |
| param_vec | output | 64 | Timing and level registers, address 2 in the low byte |

## Verification
The bench places the commit write at 1, 4 and 5 cycles after the arm write. A window counter that is off by one either rejects the last legal cycle or accepts the first late one, and one of those lock checks then disagrees. The bench also sends wrong-pattern writes and a re-arm, and puts foreign-address writes inside the window. A design that ignored the wrong pattern would lock when it should not. A design that let foreign writes close the window would miss a legal lock. After the lock, writes of all-ones and all-zeros to every protected address must leave the read-back unchanged. A leaking write enable shows up there, and a reset that failed to clear the sticky lock shows up in the reset check that follows.

// File: rtl/pcl_pkg.sv
`timescale 1ns/1ps
package pcl_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_LOCKED = 2'd2
  } seq_state_e;

  localparam logic [1:0] CODE_ARM    = 2'b11;
  localparam logic [1:0] CODE_COMMIT = 2'b01;

  localparam int ADDR_LOCK   = 0;
  localparam int ADDR_CTRL   = 1;
  localparam int ADDR_PARAM0 = 2;
endpackage

// File: rtl/pcl_rst_sync.sv
`timescale 1ns/1ps
module pcl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcl_lock_seq.sv
`timescale 1ns/1ps
module pcl_lock_seq
  import pcl_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_lock,
  input  logic [1:0] wr_bits,
  output logic [1:0] lock_bits,
  output logic       armed,
  output logic       locked
);
  localparam int CNT_W = $clog2(WINDOW + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       bits_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      SEQ_IDLE: begin
        if (wr_lock && wr_bits == CODE_ARM) begin
          state_d = SEQ_ARMED;
          cnt_d   = CNT_W'(WINDOW);
        end
      end
      SEQ_ARMED: begin
        if (wr_lock) begin
          if (wr_bits == CODE_ARM) begin
            cnt_d = CNT_W'(WINDOW);
          end else if (wr_bits == CODE_COMMIT) begin
            state_d = SEQ_LOCKED;
            cnt_d   = '0;
          end else begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
          end
        end else if (cnt_q == CNT_W'(1)) begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      SEQ_LOCKED: begin
        state_d = SEQ_LOCKED;
        cnt_d   = '0;
      end
      default: begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bits_q <= '0;
    else if (wr_lock) bits_q <= wr_bits;
  end

  assign lock_bits = bits_q;
  assign armed     = (state_q == SEQ_ARMED);
  assign locked    = (state_q == SEQ_LOCKED);
endmodule

// File: rtl/pcl_regfile.sv
`timescale 1ns/1ps
module pcl_regfile
  import pcl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int N_PARAM   = 8,
  parameter int CTRL_RW_W = 5,
  parameter int CTRL_ONE  = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      wr_allow,
  input  logic [1:0]                lock_bits,
  output logic [DATA_W-1:0]         rdata,
  output logic [CTRL_RW_W-1:0]      ctrl_bits,
  output logic [N_PARAM*DATA_W-1:0] param_flat
);
  logic                 ctrl_en;
  logic [CTRL_RW_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0]    par_q [N_PARAM];

  assign ctrl_en = we && wr_allow && (addr == ADDR_W'(ADDR_CTRL));
  assign ctrl_d  = wdata[CTRL_RW_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  for (genvar g = 0; g < N_PARAM; g++) begin : g_par
    logic par_en;
    assign par_en = we && wr_allow && (addr == ADDR_W'(ADDR_PARAM0 + g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      par_q[g] <= '0;
      else if (par_en) par_q[g] <= wdata;
    end
    assign param_flat[g*DATA_W +: DATA_W] = par_q[g];
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADDR_LOCK)) begin
      rdata[1:0] = lock_bits;
    end else if (addr == ADDR_W'(ADDR_CTRL)) begin
      rdata[CTRL_RW_W-1:0] = ctrl_q;
      rdata[CTRL_ONE]      = 1'b1;
    end else begin
      for (int i = 0; i < N_PARAM; i++) begin
        if (addr == ADDR_W'(ADDR_PARAM0 + i)) rdata = par_q[i];
      end
    end
  end

  assign ctrl_bits = ctrl_q;
endmodule

// File: rtl/prot_cfg_lock.sv
`timescale 1ns/1ps
module prot_cfg_lock
  import pcl_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int N_PARAM   = 8,
  parameter int CTRL_RW_W = 5,
  parameter int WINDOW    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  input  logic                      bus_we,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic                      cfg_locked,
  output logic [CTRL_RW_W-1:0]      det_disable,
  output logic [N_PARAM*DATA_W-1:0] param_vec
);
  logic       rst_q_n;
  logic       wr_lock;
  logic       seq_armed;
  logic [1:0] lock_bits;

  pcl_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign wr_lock = bus_we && (bus_addr == ADDR_W'(ADDR_LOCK));

  pcl_lock_seq #(.WINDOW(WINDOW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_lock   (wr_lock),
    .wr_bits   (bus_wdata[1:0]),
    .lock_bits (lock_bits),
    .armed     (seq_armed),
    .locked    (cfg_locked)
  );

  pcl_regfile #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .N_PARAM   (N_PARAM),
    .CTRL_RW_W (CTRL_RW_W),
    .CTRL_ONE  (5)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .we         (bus_we),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .wr_allow   (!cfg_locked),
    .lock_bits  (lock_bits),
    .rdata      (bus_rdata),
    .ctrl_bits  (det_disable),
    .param_flat (param_vec)
  );
endmodule

// File: rtl/pcl_checker.sv
`timescale 1ns/1ps
module pcl_checker #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int N_PARAM   = 8,
  parameter int CTRL_RW_W = 5
) (
  input logic                      clk,
  input logic                      rst_q_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic                      bus_we,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic                      cfg_locked,
  input logic                      seq_armed,
  input logic [CTRL_RW_W-1:0]      det_disable,
  input logic [N_PARAM*DATA_W-1:0] param_vec
);
  // R10
  locked_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    cfg_locked |=> cfg_locked);

  // R5
  lock_commit_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(cfg_locked) |-> $past(bus_we && bus_addr == ADDR_W'(0) &&
                                bus_wdata[1:0] == 2'b01 && seq_armed));

  // R9
  locked_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    cfg_locked |=> $stable(det_disable));

  // R9
  locked_param_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    cfg_locked |=> $stable(param_vec));

  // R3
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_addr == ADDR_W'(1)) |-> (bus_rdata[7:5] == 3'b001));

  // R2
  lock_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_addr == ADDR_W'(0)) |-> (bus_rdata[7:2] == 6'd0));

  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_addr >= ADDR_W'(10)) |-> (bus_rdata == '0));
endmodule

bind prot_cfg_lock pcl_checker u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_we      (bus_we),
  .bus_rdata   (bus_rdata),
  .cfg_locked  (cfg_locked),
  .seq_armed   (seq_armed),
  .det_disable (det_disable),
  .param_vec   (param_vec)
);

// File: tb/tb_prot_cfg_lock.sv
`timescale 1ns/1ps
module tb_prot_cfg_lock;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we;
  logic [7:0]  bus_rdata;
  logic        cfg_locked;
  logic [4:0]  det_disable;
  logic [63:0] param_vec;

  int checks = 0;
  int errors = 0;

  int m_lockbits, m_ctrl, m_arm, m_locked;
  int m_par[8];

  always #2 clk = ~clk;

  prot_cfg_lock dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .cfg_locked(cfg_locked),
    .det_disable(det_disable), .param_vec(param_vec)
  );

  function automatic int m_read(int a);
    if (a == 0) return m_lockbits;
    if (a == 1) return m_ctrl | 'h20;
    if (a >= 2 && a <= 9) return m_par[a-2];
    return 0;
  endfunction

  task automatic model_reset();
    m_lockbits = 0; m_ctrl = 0; m_arm = 0; m_locked = 0;
    for (int i = 0; i < 8; i++) m_par[i] = 0;
  endtask

  task automatic model_step();
    int a, d, b, lk;
    a = bus_addr; d = bus_wdata; b = d & 3; lk = m_locked;
    if (bus_we && a == 0) begin
      m_lockbits = b;
      if (lk == 0) begin
        if (b == 3) m_arm = 4;
        else begin
          if (b == 1 && m_arm > 0) m_locked = 1;
          m_arm = 0;
        end
      end
    end else if (m_arm > 0) begin
      m_arm--;
    end
    if (bus_we && lk == 0 && a == 1) m_ctrl = d & 'h1f;
    if (bus_we && lk == 0 && a >= 2 && a <= 9) m_par[a-2] = d;
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int a, int d, bit w, string tag);
    bus_addr = 4'(a); bus_wdata = 8'(d); bus_we = w;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check({tag, " rdata"}, int'(bus_rdata), m_read(a));
    check({tag, " locked"}, int'(cfg_locked), m_locked);
  endtask

  task automatic wr(int a, int d, string tag);
    cyc(a, d, 1'b1, tag);
  endtask

  task automatic rd(int a, string tag);
    cyc(a, 0, 1'b0, tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, 1'b0, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset values, fixed expectations
    rd(1, "R1 ctrl"); check("R1 ctrl fixed", int'(bus_rdata), 'h20);
    rd(0, "R1 lock"); check("R1 lock fixed", int'(bus_rdata), 0);
    for (int a = 2; a <= 9; a++) rd(a, "R1 param");
    check("R1 locked fixed", int'(cfg_locked), 0);

    // R2 lock register bits and reserved bits
    wr(0, 'hFE, "R2 lock fe"); check("R2 lock fe fixed", int'(bus_rdata), 'h02);
    wr(0, 'hFC, "R2 lock fc"); check("R2 lock fc fixed", int'(bus_rdata), 0);

    // R3 control register
    wr(1, 'hFF, "R3 ctrl ff"); check("R3 ctrl ff fixed", int'(bus_rdata), 'h3F);
    wr(1, 'h00, "R3 ctrl 00"); check("R3 ctrl 00 fixed", int'(bus_rdata), 'h20);
    wr(1, 'hD5, "R3 ctrl d5"); check("R3 ctrl d5 fixed", int'(bus_rdata), 'h35);

    // R4 full-width parameter storage
    for (int a = 2; a <= 9; a++) wr(a, 'hA0 + a * 7, "R4 param wr");
    for (int a = 2; a <= 9; a++) rd(a, "R4 param rd");
    rd(5, "R4 param 5"); check("R4 param 5 fixed", int'(bus_rdata), 'hA0 + 35);

    // R11 unmapped addresses
    for (int a = 10; a <= 15; a++) wr(a, 'h55, "R11 unmapped wr");
    for (int a = 0; a <= 15; a++) rd(a, "R11 sweep");
    rd(12, "R11 rd12"); check("R11 rd12 fixed", int'(bus_rdata), 0);

    // R6 commit 5 cycles after arm: rejected
    wr(0, 'h03, "R6 arm"); idle(4, "R6 wait"); wr(0, 'h01, "R6 late commit");
    check("R6 late fixed", int'(cfg_locked), 0);
    // R6 commit without arm
    wr(0, 'h01, "R6 no arm"); check("R6 no arm fixed", int'(cfg_locked), 0);

    // R7 wrong patterns cancel
    wr(0, 'h03, "R7 arm"); wr(0, 'h00, "R7 cancel00"); wr(0, 'h01, "R7 commit");
    check("R7 cancel00 fixed", int'(cfg_locked), 0);
    wr(0, 'h03, "R7 arm2"); wr(0, 'hF2, "R7 cancel10"); wr(0, 'h01, "R7 commit2");
    check("R7 cancel10 fixed", int'(cfg_locked), 0);
    // R7 re-arm restarts window: arm, 3 idle, re-arm, 3 idle, commit at +4
    wr(0, 'h03, "R7 arm3"); idle(3, "R7 w1"); wr(0, 'h03, "R7 rearm");
    idle(3, "R7 w2"); wr(0, 'h01, "R7 commit3");
    check("R7 rearm fixed", int'(cfg_locked), 1);

    // R10 reset clears lock and registers
    do_reset();
    check("R10 after reset locked", int'(cfg_locked), 0);
    rd(1, "R10 ctrl"); check("R10 ctrl fixed", int'(bus_rdata), 'h20);
    rd(4, "R10 param"); check("R10 param fixed", int'(bus_rdata), 0);

    // R8 + R5 foreign writes inside window, commit at 4th cycle
    wr(1, 'h0A, "R5 ctrl pre");
    for (int a = 2; a <= 9; a++) wr(a, 'h10 + a, "R5 param pre");
    wr(0, 'h03, "R8 arm"); wr(3, 'h77, "R8 foreign wr"); rd(7, "R8 foreign rd");
    idle(1, "R8 wait"); wr(0, 'h01, "R5 commit at 4");
    check("R5 commit 4 fixed", int'(cfg_locked), 1);
    rd(3, "R8 foreign kept"); check("R8 foreign fixed", int'(bus_rdata), 'h77);

    // R9 writes ignored after lock, reads still valid
    for (int a = 1; a <= 9; a++) wr(a, 'hFF, "R9 wr ff");
    for (int a = 1; a <= 9; a++) wr(a, 'h00, "R9 wr 00");
    for (int a = 1; a <= 9; a++) rd(a, "R9 rd");
    rd(1, "R9 ctrl"); check("R9 ctrl fixed", int'(bus_rdata), 'h2A);
    check("R9 det_disable", int'(det_disable), 'h0A);

    // R10 sticky and R2 lock register still writable
    wr(0, 'h02, "R2 after lock"); check("R2 after lock fixed", int'(bus_rdata), 'h02);
    wr(0, 'h03, "R10 arm after"); wr(0, 'h00, "R10 zero after");
    idle(6, "R10 hold"); check("R10 sticky fixed", int'(cfg_locked), 1);

    // R5 commit one cycle after arm
    do_reset();
    wr(0, 'h03, "R5 arm1"); wr(0, 'h01, "R5 commit at 1");
    check("R5 commit 1 fixed", int'(cfg_locked), 1);
    wr(2, 'h5A, "R9 post lock"); check("R9 post lock fixed", int'(bus_rdata), 0);
    do_reset();
    check("R10 final reset", int'(cfg_locked), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule